// File: doc/BRIEF.md
# I2C master register and interrupt unit

This block is the software-facing register file of an I2C master controller. A host reaches it through a simple word-addressed read/write port with a 5-bit offset. The unit holds the configuration words that steer the bit engine and produces one-cycle strobes that push and pop the transmit and receive FIFOs, launch a transfer and reset the engine. The bit engine and the FIFO storage sit outside and connect through ports.

The engine reports events as one-cycle pulses. The unit collects them into a sticky interrupt status word, and software acknowledges them by writing ones back to that word. Each status bit has a matching enable bit, and a registered interrupt line is raised while any enabled bit is pending. A single command write starts a transfer and also selects whether it closes with STOP. Software can therefore chain messages that are joined by repeated starts.

Offsets used: 0x0 divider, 0x1 control, 0x2 command, 0x3 engine status, 0x4 transmit data, 0x5 receive data, 0x6 FIFO control, 0xA target address, 0xB own address, 0xC FIFO word count, 0xD interrupt enable, 0xE interrupt status, 0xF wait count, 0x10 timeout, 0x11 general-call address.

Top module: `i2cm_reg_unit`

## Requirements
- R1: After reset every register reads 0, and irq, err_pend, cmd_go, soft_rst and fifo_flush are all 0.
- R2: Offsets 0x0 (bits DIV_W-1:0), 0xA (bits 7:0, address in 7:1 and read flag in bit 0), 0xB (bits 9:0), 0x11 (bits 7:0), 0xF and 0x10 (bits TMO_W-1:0) and 0x6 (threshold bits 15:0) read back what was written, with the other bits 0. Offsets 0x7-0x9 and 0x12-0x1F read 0, and writes to them change nothing.
- R3: Control (0x1) stores bits 31:16 (length), 6 (enable), 4 (master), 1 (read direction) and 0 (10-bit address). Writing bit 8 drives soft_rst high for exactly the one cycle after the write. Bit 8 always reads 0.
- R4: A soft reset clears the interrupt status word and pulses fifo_flush. It keeps the divider and all other configuration.
- R5: A write to command (0x2) raises cmd_go for exactly the next cycle. The same write sets cmd_start/stop/read/write/ack from write bits 7/6/5/4/3, and those bits read back in the same positions.
- R6: An event pulse on status bit 25, 13, 12, 11, 4, 3, 2 or 0 sets that bit sticky in 0xE one cycle later. Pulses on any other bit are ignored.
- R7: Writing 0xE clears exactly the bits that are 1 in the written value. When a set pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: Interrupt enable (0xD) stores only the eight bits of R6. irq is registered: it is high one cycle after (status AND enable) becomes nonzero, and it is low one cycle after that AND becomes zero.
- R9: A write to 0x4 raises tx_push in the same cycle, with tx_byte equal to write bits 7:0. A read of 0x5 raises rx_pop in the same cycle and returns rx_byte. A write to 0x6 with bit 16 set pulses fifo_flush for one cycle, and bit 16 reads 0.
- R10: Offset 0x3 returns eng_status and offset 0xC returns fifo_wcnt, zero-extended. Writes to 0x3, 0x5 and 0xC have no effect.
- R11: err_pend is high while any of status bits 25 (address NACK), 11 (arbitration lost) or 0 (bus error) is set, whatever the enables hold.
- R12: Read data appears on bus_rdata in the cycle after bus_rd and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_pulse | input | 32 | One-cycle event pulses from the engine |
| eng_status | input | 32 | Live engine status word |
| fifo_wcnt | input | CNT_W | FIFO word count |
| rx_byte | input | 8 | Head of the receive FIFO |
| tx_push | output | 1 | Transmit FIFO push |
| tx_byte | output | 8 | Byte to push |
| rx_pop | output | 1 | Receive FIFO pop |
| fifo_flush | output | 1 | FIFO reset pulse |
| soft_rst | output | 1 | Engine reset pulse |
| cmd_go | output | 1 | Transfer launch pulse |
| cmd_start | output | 1 | Issue START |
| cmd_stop | output | 1 | Finish with STOP |
| cmd_read | output | 1 | Read transfer |
| cmd_write | output | 1 | Write transfer |
| cmd_ack | output | 1 | Acknowledge received bytes |
| cfg_ctrl | output | 32 | Stored control word |
| cfg_div | output | DIV_W | Clock divider |
| cfg_target | output | 8 | Target address and read flag |
| cfg_own | output | 10 | Own address |
| cfg_gcall | output | 8 | General-call address |
| cfg_fifo_thr | output | 16 | FIFO thresholds |
| cfg_wait | output | TMO_W | Wait count |
| cfg_timeout | output | TMO_W | Timeout |
| irq | output | 1 | Interrupt, active high |
| err_pend | output | 1 | Error-group event pending |

## Verification
Most faults in this unit show up at the ports within one or two cycles. A wrong decode puts a written value on another offset's readback, or it loses the value. A status bit that is stuck or not sticky shows in the next read of 0xE and in irq one cycle later. A clear that is too wide or too narrow leaves the wrong residue in the status word. A soft reset that lasts too long or touches configuration shows in soft_rst and in the divider readback right after the reset. The bench writes complementary patterns to all 32 offsets and sweeps every event bit one at a time, so aliasing and mask faults show up directly.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam logic [4:0] OFS_DIV   = 5'h00;
  localparam logic [4:0] OFS_CTRL  = 5'h01;
  localparam logic [4:0] OFS_CMD   = 5'h02;
  localparam logic [4:0] OFS_ESTAT = 5'h03;
  localparam logic [4:0] OFS_TXD   = 5'h04;
  localparam logic [4:0] OFS_RXD   = 5'h05;
  localparam logic [4:0] OFS_FCTL  = 5'h06;
  localparam logic [4:0] OFS_TGT   = 5'h0A;
  localparam logic [4:0] OFS_OWN   = 5'h0B;
  localparam logic [4:0] OFS_WCNT  = 5'h0C;
  localparam logic [4:0] OFS_IEN   = 5'h0D;
  localparam logic [4:0] OFS_ISTS  = 5'h0E;
  localparam logic [4:0] OFS_WAIT  = 5'h0F;
  localparam logic [4:0] OFS_TMO   = 5'h10;
  localparam logic [4:0] OFS_GCALL = 5'h11;

  // event bit positions
  localparam int EV_NACK = 25, EV_AACK = 13, EV_DONE = 12, EV_ARB = 11;
  localparam int EV_FULL = 4, EV_EMPTY = 3, EV_HI = 2, EV_BERR = 0;

  localparam logic [31:0] EV_MASK  = (32'd1 << EV_NACK) | (32'd1 << EV_AACK) |
                                     (32'd1 << EV_DONE) | (32'd1 << EV_ARB)  |
                                     (32'd1 << EV_FULL) | (32'd1 << EV_EMPTY)|
                                     (32'd1 << EV_HI)   | (32'd1 << EV_BERR);
  localparam logic [31:0] ERR_MASK = (32'd1 << EV_NACK) | (32'd1 << EV_ARB) |
                                     (32'd1 << EV_BERR);
  localparam logic [31:0] CTRL_KEEP = 32'hFFFF_0053;
  localparam int CTRL_SRST = 8;
  localparam int FCTL_FLUSH = 16;

  // next sticky status: clears applied first, then sets, so a set wins
  function automatic logic [31:0] sts_next(input logic [31:0] cur,
                                           input logic [31:0] set,
                                           input logic [31:0] clr);
    return ((cur & ~clr) | set) & EV_MASK;
  endfunction
endpackage

// File: rtl/i2cm_sts_irq.sv
module i2cm_sts_irq
  import i2cm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        srst,
  input  logic        en_wr,
  input  logic        clr_wr,
  input  logic [31:0] wdata,
  input  logic [31:0] evt,
  output logic [31:0] sts,
  output logic [31:0] en,
  output logic        irq,
  output logic        err_pend
);
  logic [31:0] clr_vec;
  logic [31:0] set_vec;
  logic        pend;

  assign clr_vec = clr_wr ? wdata : 32'd0;
  assign set_vec = evt & EV_MASK;
  assign pend    = |(sts & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
      en  <= '0;
      irq <= 1'b0;
    end else begin
      sts <= srst ? 32'd0 : sts_next(sts, set_vec, clr_vec);
      if (en_wr) en <= wdata & EV_MASK;
      irq <= pend;
    end
  end

  assign err_pend = |(sts & ERR_MASK);

  AST_SET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 0 && !srst) |=> ((sts & $past(set_vec)) == $past(set_vec))); // R7
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & ~$past(sts)) & ~$past(evt)) == 0); // R6
  AST_CLEAR_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(srst) |-> ((~sts & $past(sts)) & ~$past(clr_vec)) == 0); // R7
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> irq); // R8
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> !irq); // R8
endmodule

// File: rtl/i2cm_cmd_ctl.sv
module i2cm_cmd_ctl
  import i2cm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic        cmd_wr,
  input  logic [31:0] wdata,
  output logic [31:0] ctrl,
  output logic [4:0]  cmd,
  output logic        go,
  output logic        srst
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      cmd  <= '0;
      go   <= 1'b0;
      srst <= 1'b0;
    end else begin
      go   <= cmd_wr;
      srst <= ctrl_wr & wdata[CTRL_SRST];
      if (ctrl_wr) ctrl <= wdata & CTRL_KEEP;
      if (cmd_wr)  cmd  <= wdata[7:3];
    end
  end

  AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    srst && !$past(ctrl_wr) |-> 1'b0); // R3
  AST_SRST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (srst && !ctrl_wr) |=> !srst); // R3
  AST_GO_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> $past(cmd_wr)); // R5
endmodule

// File: rtl/i2cm_reg_unit.sv
module i2cm_reg_unit
  import i2cm_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int TMO_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [4:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [31:0]      evt_pulse,
  input  logic [31:0]      eng_status,
  input  logic [CNT_W-1:0] fifo_wcnt,
  input  logic [7:0]       rx_byte,
  output logic             tx_push,
  output logic [7:0]       tx_byte,
  output logic             rx_pop,
  output logic             fifo_flush,
  output logic             soft_rst,
  output logic             cmd_go,
  output logic             cmd_start,
  output logic             cmd_stop,
  output logic             cmd_read,
  output logic             cmd_write,
  output logic             cmd_ack,
  output logic [31:0]      cfg_ctrl,
  output logic [DIV_W-1:0] cfg_div,
  output logic [7:0]       cfg_target,
  output logic [9:0]       cfg_own,
  output logic [7:0]       cfg_gcall,
  output logic [15:0]      cfg_fifo_thr,
  output logic [TMO_W-1:0] cfg_wait,
  output logic [TMO_W-1:0] cfg_timeout,
  output logic             irq,
  output logic             err_pend
);
  localparam int NOFS = 32;

  logic [NOFS-1:0] wsel;
  logic [31:0]     sts_w, en_w, rd_mux;
  logic [4:0]      cmd_w;
  logic            flush_q;

  assign wsel = bus_wr ? (NOFS'(1) << bus_addr) : '0;

  i2cm_cmd_ctl u_cmd (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(wsel[OFS_CTRL]), .cmd_wr(wsel[OFS_CMD]), .wdata(bus_wdata),
    .ctrl(cfg_ctrl), .cmd(cmd_w), .go(cmd_go), .srst(soft_rst)
  );

  i2cm_sts_irq u_sts (
    .clk(clk), .rst_n(rst_n), .srst(soft_rst),
    .en_wr(wsel[OFS_IEN]), .clr_wr(wsel[OFS_ISTS]), .wdata(bus_wdata),
    .evt(evt_pulse), .sts(sts_w), .en(en_w), .irq(irq), .err_pend(err_pend)
  );

  assign {cmd_start, cmd_stop, cmd_read, cmd_write, cmd_ack} = cmd_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_div      <= '0;
      cfg_target   <= '0;
      cfg_own      <= '0;
      cfg_gcall    <= '0;
      cfg_fifo_thr <= '0;
      cfg_wait     <= '0;
      cfg_timeout  <= '0;
      flush_q      <= 1'b0;
    end else begin
      flush_q <= wsel[OFS_FCTL] & bus_wdata[FCTL_FLUSH];
      if (wsel[OFS_DIV])   cfg_div      <= bus_wdata[DIV_W-1:0];
      if (wsel[OFS_TGT])   cfg_target   <= bus_wdata[7:0];
      if (wsel[OFS_OWN])   cfg_own      <= bus_wdata[9:0];
      if (wsel[OFS_GCALL]) cfg_gcall    <= bus_wdata[7:0];
      if (wsel[OFS_FCTL])  cfg_fifo_thr <= bus_wdata[15:0];
      if (wsel[OFS_WAIT])  cfg_wait     <= bus_wdata[TMO_W-1:0];
      if (wsel[OFS_TMO])   cfg_timeout  <= bus_wdata[TMO_W-1:0];
    end
  end

  assign fifo_flush = flush_q | soft_rst;
  assign tx_push    = wsel[OFS_TXD];
  assign tx_byte    = bus_wdata[7:0];
  assign rx_pop     = bus_rd && (bus_addr == OFS_RXD);

  always_comb begin
    case (bus_addr)
      OFS_DIV:   rd_mux = 32'(cfg_div);
      OFS_CTRL:  rd_mux = cfg_ctrl;
      OFS_CMD:   rd_mux = {24'd0, cmd_w, 3'd0};
      OFS_ESTAT: rd_mux = eng_status;
      OFS_RXD:   rd_mux = {24'd0, rx_byte};
      OFS_FCTL:  rd_mux = {16'd0, cfg_fifo_thr};
      OFS_TGT:   rd_mux = {24'd0, cfg_target};
      OFS_OWN:   rd_mux = {22'd0, cfg_own};
      OFS_WCNT:  rd_mux = 32'(fifo_wcnt);
      OFS_IEN:   rd_mux = en_w;
      OFS_ISTS:  rd_mux = sts_w;
      OFS_WAIT:  rd_mux = 32'(cfg_wait);
      OFS_TMO:   rd_mux = 32'(cfg_timeout);
      OFS_GCALL: rd_mux = {24'd0, cfg_gcall};
      default:   rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata)); // R12
  AST_FLUSH_ON_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> fifo_flush); // R4
  AST_ERR_IMPLIES_STS: assert property (@(posedge clk) disable iff (!rst_n)
    err_pend |-> (sts_w != 0)); // R11
endmodule

// File: tb/test_i2cm_reg_unit.sv
`timescale 1ns/1ps
module test_i2cm_reg_unit;
  localparam int DIV_W = 16, TMO_W = 16, CNT_W = 8;
  localparam logic [31:0] EVM = 32'h0200_381D;
  localparam logic [31:0] ERM = 32'h0200_0801;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, evt_pulse = 0, eng_status = 32'h1357_9BDF;
  logic [CNT_W-1:0] fifo_wcnt = 8'h5C;
  logic [7:0] rx_byte = 8'hE7, tx_byte, cfg_target, cfg_gcall;
  logic tx_push, rx_pop, fifo_flush, soft_rst, cmd_go, cmd_start, cmd_stop;
  logic cmd_read, cmd_write, cmd_ack, irq, err_pend;
  logic [31:0] cfg_ctrl;
  logic [DIV_W-1:0] cfg_div;
  logic [9:0] cfg_own;
  logic [15:0] cfg_fifo_thr;
  logic [TMO_W-1:0] cfg_wait, cfg_timeout;

  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  i2cm_reg_unit #(.DIV_W(DIV_W), .TMO_W(TMO_W), .CNT_W(CNT_W)) i_i2cm_reg_unit (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_rd = 0;
  endtask

  // expected readback of an offset after writing w there (status/enable idle)
  function automatic logic [31:0] exp_rd(input int a, input logic [31:0] w);
    case (a)
      0:  return w % (32'd1 << DIV_W);
      1:  return {w[31:16], 9'd0, w[6], 1'b0, w[4], 2'b0, w[1], w[0]};
      2:  return w & 32'h0000_00F8;
      3:  return eng_status;
      5:  return {24'd0, rx_byte};
      6:  return w % 32'h1_0000;
      10: return w % 32'h100;
      11: return w % 32'h400;
      12: return {24'd0, fifo_wcnt};
      13: return w & EVM;
      15, 16: return w % (32'd1 << TMO_W);
      17: return w % 32'h100;
      default: return 32'd0;
    endcase
  endfunction

  task automatic finish_run;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 strobes", {28'd0, cmd_go, soft_rst, fifo_flush, err_pend}, 0);
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), rv);
      chk("R1 reset read", rv, (a == 3) ? eng_status : (a == 5) ? {24'd0, rx_byte} :
                               (a == 12) ? {24'd0, fifo_wcnt} : 32'd0);
    end

    // R2 R3 R5 R8 R10 R12: write every offset, then read all back
    for (int p = 0; p < 2; p++) begin
      logic [31:0] pat [32];
      for (int a = 0; a < 32; a++) begin
        pat[a] = (p == 0) ? (32'hA5C3_96F0 ^ (32'(a) * 32'h0101_0101))
                          : ~(32'hA5C3_96F0 ^ (32'(a) * 32'h0101_0101));
        wr(5'(a), pat[a]);
      end
      for (int a = 0; a < 32; a++) begin
        rd(5'(a), rv);
        chk($sformatf("R2 R10 readback ofs %0d", a), rv, exp_rd(a, pat[a]));
      end
    end
    wr(5'h0D, 32'd0);

    // R5 command strobe
    wr(5'h02, 32'h0000_00C8);
    chk("R5 go high", {31'd0, cmd_go}, 1);
    chk("R5 bits", {27'd0, cmd_start, cmd_stop, cmd_read, cmd_write, cmd_ack}, 5'b11001);
    @(negedge clk);
    chk("R5 go one cycle", {31'd0, cmd_go}, 0);

    // R9 FIFO port strobes
    @(negedge clk); bus_wr = 1; bus_addr = 5'h04; bus_wdata = 32'hFFFF_FF3C; #1;
    chk("R9 tx_push", {31'd0, tx_push}, 1);
    chk("R9 tx_byte", {24'd0, tx_byte}, 32'h3C);
    @(negedge clk); bus_wr = 0; bus_rd = 1; bus_addr = 5'h05; #1;
    chk("R9 rx_pop", {31'd0, rx_pop}, 1);
    @(negedge clk); bus_rd = 0;
    wr(5'h06, 32'h0001_1234);
    chk("R9 flush", {31'd0, fifo_flush}, 1);
    @(negedge clk);
    chk("R9 flush one cycle", {31'd0, fifo_flush}, 0);
    rd(5'h06, rv); chk("R9 bit16 reads 0", rv, 32'h1234);

    // R6 R8 R11: sweep every event bit with all enables on
    wr(5'h0D, 32'hFFFF_FFFF);
    for (int b = 0; b < 32; b++) begin
      logic imp;
      imp = EVM[b];
      @(negedge clk); evt_pulse = 32'd1 << b;
      @(negedge clk); evt_pulse = 0;
      chk($sformatf("R11 err bit %0d", b), {31'd0, err_pend}, {31'd0, ERM[b]});
      @(negedge clk);
      chk($sformatf("R8 irq bit %0d", b), {31'd0, irq}, {31'd0, imp});
      rd(5'h0E, rv);
      chk($sformatf("R6 sticky bit %0d", b), rv, imp ? (32'd1 << b) : 32'd0);
      wr(5'h0E, 32'hFFFF_FFFF);
      @(negedge clk);
      chk($sformatf("R8 irq drop %0d", b), {31'd0, irq}, 0);
    end

    // R8 masked bit does not raise irq
    wr(5'h0D, 32'd1 << 12);
    @(negedge clk); evt_pulse = 32'd1 << 2;
    @(negedge clk); evt_pulse = 0;
    @(negedge clk);
    chk("R8 masked no irq", {31'd0, irq}, 0);

    // R7 exact clear and set-wins
    @(negedge clk); evt_pulse = (32'd1 << 12) | (32'd1 << 3);
    @(negedge clk); evt_pulse = 0;
    wr(5'h0E, 32'd1 << 3);
    rd(5'h0E, rv); chk("R7 exact clear", rv, (32'd1 << 12) | (32'd1 << 2));
    @(negedge clk); bus_wr = 1; bus_addr = 5'h0E; bus_wdata = (32'd1 << 12) | (32'd1 << 2);
    evt_pulse = 32'd1 << 12;
    @(negedge clk); bus_wr = 0; evt_pulse = 0;
    rd(5'h0E, rv); chk("R7 set wins", rv, 32'd1 << 12);

    // R3 R4 soft reset
    wr(5'h00, 32'h0000_00A1);
    @(negedge clk); evt_pulse = 32'd1 << 25;
    @(negedge clk); evt_pulse = 0;
    wr(5'h01, 32'h0005_0150);
    chk("R3 soft_rst pulse", {30'd0, soft_rst, fifo_flush}, 2'b11);
    @(negedge clk);
    chk("R3 soft_rst one cycle", {31'd0, soft_rst}, 0);
    rd(5'h0E, rv); chk("R4 status cleared", rv, 0);
    chk("R4 err cleared", {31'd0, err_pend}, 0);
    rd(5'h00, rv); chk("R4 divider kept", rv, 32'hA1);
    rd(5'h01, rv); chk("R3 ctrl fields", rv, 32'h0005_0050);

    // R12 rdata holds
    rd(5'h00, rv);
    repeat (3) @(negedge clk);
    chk("R12 rdata hold", bus_rdata, 32'hA1);

    finish_run();
  end
endmodule